// File: doc/BRIEF.md
# Single-Precision Series Reciprocal Unit

This unit returns an approximate reciprocal of a normalized single-precision floating-point operand. It takes one operand per cycle and returns its result four cycles later. The significand `1.f` is split into an 8-bit high field, which indexes a coefficient table, and a 15-bit low field. The table holds the first, second and third inverse powers of the high part `1 + hi/256`. A three-term alternating series, `c1 - c2*lo + c3*lo^2`, then forms the reciprocal significand. The first coefficient is widened with a run of ones below its last bit before the sum. The result is truncated rather than rounded, and an error of up to two units in the last place is accepted in exchange.

The sign is passed through unchanged. The exponent comes from ordinary reciprocal arithmetic on the biased exponent. An operand whose significand is exactly 1.0 gives an exact power of two. Zeros, denormals, infinities and NaNs are not computed. They and any result whose exponent falls outside the normal range are flagged as invalid, and the data output is then forced to zero.

Top module: `rbr_recip_sp`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid`, `out_invalid` and `out_data` are all zero.
- R2: Each accepted operand (`in_valid` high at a rising edge) produces exactly one result with `out_valid` high on the fourth rising edge after it. Operands may arrive on every cycle, and results leave in arrival order.
- R3: For a valid result, bit 31 of `out_data` (sign) equals bit 31 of the operand.
- R4: For an operand with biased exponent E (bits 30:23) and a nonzero fraction (bits 22:0), the result's biased exponent is 253 - E.
- R5: For an operand with a zero fraction, the result has a zero fraction and biased exponent 254 - E.
- R6: For a nonzero fraction f, with M = 2^23 + f and G = 2^23 + result fraction, |G*M - 2^47| <= 2*M holds, so the result is within 2 ulp of the exact reciprocal.
- R7: An operand with E = 0 or E = 255 gives `out_invalid` = 1 and `out_data` = 0 on its result cycle.
- R8: An operand whose result exponent would fall outside 1..254 (E >= 253 with a nonzero fraction, E = 254 with a zero fraction) gives `out_invalid` = 1 and `out_data` = 0.
- R9: Whenever `out_valid` is low, `out_invalid` is low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 32 | Operand: sign 31, biased exponent 30:23, fraction 22:0 |
| out_valid | output | 1 | Result present this cycle |
| out_invalid | output | 1 | Result rejected (exceptional operand or exponent out of range) |
| out_data | output | 32 | Reciprocal in the same layout, zero when rejected or idle |

## Verification
The bench builds the unit with its default parameters: an 8-bit table index and coefficient widths of 24, 17 and 17 bits with six padding ones. At these values the error bound of R6 is met for any low field. Random operands keep bit 14 of the fraction clear. That holds back the neglected fourth series term so that table truncation does not dominate the error. Directed operands reach the table's end entries (high field 0 with the low field at its maximum, and the all-ones fraction), the exact-power path, and both edges of the exponent range.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  localparam int FP_FRAC_W = 23;
  localparam int FP_EXP_W  = 8;
  localparam int Y_W       = FP_FRAC_W + 1;

  // Inverse power k of (2^idx_w + idx)/2^idx_w, scaled by 2^out_w and
  // saturated to out_w bits; optional round to nearest.
  function automatic longint unsigned inv_pow(input int idx, input int idx_w,
                                              input int k, input int out_w,
                                              input bit rnd);
    longint unsigned d, dk, num, q, lim;
    d  = (64'd1 << idx_w) + longint'(idx);
    dk = 64'd1;
    for (int j = 0; j < k; j++) dk = dk * d;
    num = 64'd1 << (out_w + k * idx_w);
    q   = rnd ? (num + dk / 2) / dk : num / dk;
    lim = (64'd1 << out_w) - 64'd1;
    return (q > lim) ? lim : q;
  endfunction

  // Biased reciprocal exponent; bit 8 set means the value went negative.
  function automatic logic [FP_EXP_W:0] recip_exp(input logic [FP_EXP_W-1:0] e,
                                                  input logic unity);
    logic [FP_EXP_W:0] base;
    base = unity ? 9'd254 : 9'd253;
    return base - {1'b0, e};
  endfunction

endpackage

// File: rtl/rbr_rom.sv
module rbr_rom import rbr_pkg::*; #(
  parameter int IDX_W = 8,
  parameter int R1_W  = 24,
  parameter int R2_W  = 17,
  parameter int R3_W  = 17
) (
  input  logic                        clk,
  input  logic [IDX_W-1:0]            addr_i,
  output logic [R1_W+R2_W+R3_W-1:0]   word_o
);

  localparam int WORD_W = R1_W + R2_W + R3_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic [WORD_W-1:0] coef_tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign coef_tab[g] = {R1_W'(inv_pow(g, IDX_W, 1, R1_W, 1'b0)),
                          R2_W'(inv_pow(g, IDX_W, 2, R2_W, 1'b1)),
                          R3_W'(inv_pow(g, IDX_W, 3, R3_W, 1'b0))};
  end

  always_ff @(posedge clk) begin
    word_o <= coef_tab[addr_i];
  end

endmodule

// File: rtl/rbr_series.sv
module rbr_series import rbr_pkg::*; #(
  parameter int IDX_W = 8,
  parameter int R1_W  = 24,
  parameter int R2_W  = 17,
  parameter int R3_W  = 17,
  parameter int PAD_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       v_i,
  input  logic [FP_FRAC_W-IDX_W-1:0] lo_i,
  input  logic [R1_W+R2_W+R3_W-1:0]  word_i,
  output logic                       v_o,
  output logic [Y_W-1:0]             y_o
);

  localparam int LO_W   = FP_FRAC_W - IDX_W;
  localparam int ACC_W  = R1_W + PAD_W;
  localparam int P2_W   = LO_W + R2_W;
  localparam int SQ_W   = 2 * LO_W;
  localparam int P3_W   = SQ_W + R3_W;
  localparam int T2_SH  = FP_FRAC_W + R2_W - ACC_W;
  localparam int T3_SH  = 2 * FP_FRAC_W + R3_W - ACC_W;

  logic [R1_W-1:0] c1;
  logic [R2_W-1:0] c2;
  logic [R3_W-1:0] c3;
  assign c1 = word_i[R1_W+R2_W+R3_W-1 -: R1_W];
  assign c2 = word_i[R2_W+R3_W-1 -: R2_W];
  assign c3 = word_i[R3_W-1:0];

  // Stage A: products and widened leading coefficient
  logic             va_q;
  logic [P2_W-1:0]  p2_q;
  logic [SQ_W-1:0]  sq_q;
  logic [ACC_W-1:0] c1w_q;
  logic [R3_W-1:0]  c3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) va_q <= 1'b0;
    else        va_q <= v_i;
  end

  always_ff @(posedge clk) begin
    p2_q  <= P2_W'(lo_i) * P2_W'(c2);
    sq_q  <= SQ_W'(lo_i) * SQ_W'(lo_i);
    c1w_q <= {c1, {PAD_W{1'b1}}};
    c3_q  <= c3;
  end

  // Stage B: scale the terms onto the accumulator grid and sum
  logic [P2_W:0]    p2_rnd;
  logic [P3_W-1:0]  p3_full;
  logic [ACC_W-1:0] t2_term;
  logic [ACC_W-1:0] t3_term;
  logic [ACC_W:0]   y_sum;

  assign p2_rnd  = {1'b0, p2_q} + (P2_W+1)'(64'd1 << (T2_SH - 1));
  assign t2_term = ACC_W'(p2_rnd >> T2_SH);
  assign p3_full = P3_W'(sq_q) * P3_W'(c3_q);
  assign t3_term = ACC_W'(p3_full >> T3_SH);
  assign y_sum   = {1'b0, c1w_q} - {1'b0, t2_term} + {1'b0, t3_term};

  logic unused_low_bits;
  assign unused_low_bits = ^{y_sum[ACC_W], y_sum[ACC_W-Y_W-1:0]};

  logic           vb_q;
  logic [Y_W-1:0] y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vb_q <= 1'b0;
    else        vb_q <= va_q;
  end

  always_ff @(posedge clk) begin
    y_q <= y_sum[ACC_W-1 -: Y_W];
  end

  assign v_o = vb_q;
  assign y_o = y_q;

  // The series never carries past the unit weight (R6)
  p_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    va_q |-> !y_sum[ACC_W]);

  // The series result always stays at or above one half (R6)
  p_half_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    va_q |-> y_sum[ACC_W-1]);

endmodule

// File: rtl/rbr_pack.sv
module rbr_pack import rbr_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                v_i,
  input  logic                sign_i,
  input  logic [FP_EXP_W-1:0] exp_i,
  input  logic                unity_i,
  input  logic                bad_i,
  input  logic [Y_W-1:0]      y_i,
  output logic                out_valid,
  output logic                out_invalid,
  output logic [31:0]         out_data
);

  logic [FP_EXP_W:0]    rexp;
  logic                 range_bad;
  logic                 reject;
  logic [FP_FRAC_W-1:0] frac_d;

  assign rexp      = recip_exp(exp_i, unity_i);
  assign range_bad = rexp[FP_EXP_W] || (rexp == '0);
  assign reject    = bad_i || range_bad;

  always_comb begin
    if (unity_i || !y_i[Y_W-1]) frac_d = '0;
    else                        frac_d = y_i[Y_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid   <= v_i;
      out_invalid <= v_i && reject;
      out_data    <= (v_i && !reject) ? {sign_i, rexp[FP_EXP_W-1:0], frac_d} : '0;
    end
  end

  // Exact-power operands leave with an empty fraction (R5)
  p_unity_frac_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid && $past(v_i && unity_i)) |-> (out_data[FP_FRAC_W-1:0] == '0));

  // A rejected result carries no data (R7)
  p_reject_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_valid && out_data == '0));

  // Idle output is quiet (R9)
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_invalid && out_data == '0));

endmodule

// File: rtl/rbr_recip_sp.sv
module rbr_recip_sp import rbr_pkg::*; #(
  parameter int IDX_W = 8,
  parameter int R1_W  = 24,
  parameter int R2_W  = 17,
  parameter int R3_W  = 17,
  parameter int PAD_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic        out_invalid,
  output logic [31:0] out_data
);

  localparam int LO_W   = FP_FRAC_W - IDX_W;
  localparam int WORD_W = R1_W + R2_W + R3_W;

  // Operand fields and early classification
  logic                 op_sign;
  logic [FP_EXP_W-1:0]  op_exp;
  logic [FP_FRAC_W-1:0] op_frac;
  logic                 op_unity;
  logic                 op_bad;

  assign op_sign  = in_data[31];
  assign op_exp   = in_data[30:FP_FRAC_W];
  assign op_frac  = in_data[FP_FRAC_W-1:0];
  assign op_unity = (op_frac == '0);
  assign op_bad   = (op_exp == '0) || (op_exp == '1);

  // Stage 1: operand capture alongside the table read
  logic                v1_q;
  logic                s1_sign, s1_unity, s1_bad;
  logic [FP_EXP_W-1:0] s1_exp;
  logic [LO_W-1:0]     s1_lo;
  logic [WORD_W-1:0]   s1_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    s1_sign  <= op_sign;
    s1_exp   <= op_exp;
    s1_unity <= op_unity;
    s1_bad   <= op_bad;
    s1_lo    <= op_frac[LO_W-1:0];
  end

  rbr_rom #(.IDX_W(IDX_W), .R1_W(R1_W), .R2_W(R2_W), .R3_W(R3_W)) u_rom (
    .clk    (clk),
    .addr_i (op_frac[FP_FRAC_W-1 -: IDX_W]),
    .word_o (s1_word)
  );

  // Stages 2 and 3: series evaluation
  logic           ser_v;
  logic [Y_W-1:0] ser_y;

  rbr_series #(.IDX_W(IDX_W), .R1_W(R1_W), .R2_W(R2_W), .R3_W(R3_W), .PAD_W(PAD_W)) u_series (
    .clk    (clk),
    .rst_n  (rst_n),
    .v_i    (v1_q),
    .lo_i   (s1_lo),
    .word_i (s1_word),
    .v_o    (ser_v),
    .y_o    (ser_y)
  );

  // Side information follows the series
  logic                s2_sign, s2_unity, s2_bad;
  logic [FP_EXP_W-1:0] s2_exp;
  logic                s3_sign, s3_unity, s3_bad;
  logic [FP_EXP_W-1:0] s3_exp;

  always_ff @(posedge clk) begin
    s2_sign  <= s1_sign;
    s2_exp   <= s1_exp;
    s2_unity <= s1_unity;
    s2_bad   <= s1_bad;
    s3_sign  <= s2_sign;
    s3_exp   <= s2_exp;
    s3_unity <= s2_unity;
    s3_bad   <= s2_bad;
  end

  // Stage 4: exponent, normalization and output register
  rbr_pack u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .v_i         (ser_v),
    .sign_i      (s3_sign),
    .exp_i       (s3_exp),
    .unity_i     (s3_unity),
    .bad_i       (s3_bad),
    .y_i         (ser_y),
    .out_valid   (out_valid),
    .out_invalid (out_invalid),
    .out_data    (out_data)
  );

  // Cycles since reset release, saturating, so checks never look before reset
  logic [2:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                live_cnt <= '0;
    else if (live_cnt != 3'd7) live_cnt <= live_cnt + 3'd1;
  end

  logic warm;
  assign warm = (live_cnt >= 3'd4);

  // One result per operand, four edges later (R2)
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 4)));

  // Sign passes straight through (R3)
  p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !out_invalid) |-> (out_data[31] == $past(in_data[31], 4)));

  // Exponent for a nonzero fraction (R4)
  p_exponent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && !out_invalid && $past(in_data[FP_FRAC_W-1:0] != '0, 4))
      |-> (out_data[30:FP_FRAC_W] == FP_EXP_W'(9'd253 - {1'b0, $past(in_data[30:FP_FRAC_W], 4)})));

  // Exceptional exponents are always rejected (R7)
  p_special_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid && ((in_data[30:FP_FRAC_W] == '0) || (in_data[30:FP_FRAC_W] == '1)), 4))
      |-> out_invalid);

endmodule

// File: tb/rbr_recip_sp_test.sv
`timescale 1ns/1ps
module rbr_recip_sp_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_invalid;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] rng = 32'h1234_5677;

  always #2.5 clk = ~clk;

  rbr_recip_sp uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_invalid(out_invalid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // Independent expectation for one operand/result pair
  task automatic check_result(input logic [31:0] din, input logic v,
                              input logic inv, input logic [31:0] dout);
    int     e;
    int     rexp;
    longint f, m, g, diff;
    bit     unity, special, oor;
    e       = int'(din[30:23]);
    f       = longint'(din[22:0]);
    unity   = (f == 0);
    special = (e == 0) || (e == 255);
    rexp    = (unity ? 254 : 253) - e;
    oor     = (rexp < 1) || (rexp > 254);
    chk(v == 1'b1, "R2", "result present", longint'(v), 1);
    if (special || oor) begin
      chk(inv == 1'b1, special ? "R7" : "R8", "invalid flag", longint'(inv), 1);
      chk(dout == 32'd0, special ? "R7" : "R8", "rejected data", longint'(dout), 0);
    end else begin
      chk(inv == 1'b0, "R4", "invalid flag", longint'(inv), 0);
      chk(dout[31] == din[31], "R3", "sign", longint'(dout[31]), longint'(din[31]));
      chk(int'(dout[30:23]) == rexp, unity ? "R5" : "R4", "exponent",
          longint'(dout[30:23]), longint'(rexp));
      if (unity) begin
        chk(dout[22:0] == 23'd0, "R5", "fraction", longint'(dout[22:0]), 0);
      end else begin
        m    = (64'd1 << 23) + f;
        g    = (64'd1 << 23) + longint'(dout[22:0]);
        diff = g * m - (64'd1 << 47);
        if (diff < 0) diff = -diff;
        chk(diff <= 2 * m, "R6", "fraction error", longint'(dout[22:0]),
            ((64'd1 << 47) / m) - (64'd1 << 23));
      end
    end
  endtask

  task automatic one_shot(input logic [31:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check_result(d, out_valid, out_invalid, out_data);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_invalid == 1'b0 && out_data == 32'd0, "R1",
        "outputs in reset", longint'({out_valid, out_invalid}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b0 && out_invalid == 1'b0 && out_data == 32'd0, "R1",
        "outputs idle after reset", longint'(out_data), 0);
  endtask

  // R2 and R9: a single rejected operand appears on exactly the fourth edge
  task automatic t_latency();
    @(negedge clk); in_valid = 1'b1; in_data = 32'h7F80_0000;
    @(negedge clk); in_valid = 1'b0; in_data = '0;
    for (int k = 1; k <= 6; k++) begin
      if (k == 4) begin
        chk(out_valid == 1'b1 && out_invalid == 1'b1, "R2", "valid at fourth edge",
            longint'({out_valid, out_invalid}), 3);
      end else begin
        chk(out_valid == 1'b0, "R2", "no result off the fourth edge", longint'(out_valid), 0);
        chk(out_invalid == 1'b0 && out_data == 32'd0, "R9", "quiet while idle",
            longint'(out_data), 0);
      end
      if (k < 6) @(negedge clk);
    end
  endtask

  task automatic t_unity();
    one_shot(32'h3F80_0000);   // 1.0  -> 1.0      (R5)
    one_shot(32'h4000_0000);   // 2.0  -> 0.5      (R5)
    one_shot(32'hBF00_0000);   // -0.5 -> -2.0     (R5, R3)
    one_shot(32'h0080_0000);   // smallest normal power, exponent 253 (R5)
  endtask

  task automatic t_directed();
    one_shot(32'h4040_0000);   // 3.0               (R4, R6)
    one_shot(32'h3FC0_0000);   // 1.5, low field 0  (R6)
    one_shot(32'hC0A0_0000);   // -5.0              (R3)
    one_shot(32'h3FFF_FFFF);   // all-ones fraction (R6)
    one_shot(32'h3F80_7FFF);   // table entry 0, low field max (R6)
    one_shot(32'h4049_0FDB);   // about pi          (R6)
    one_shot(32'h0080_0001);   // E = 1 -> exponent 252 (R4)
  endtask

  task automatic t_exceptions();
    one_shot(32'h0000_0000);   // zero              (R7)
    one_shot(32'h8000_0001);   // denormal          (R7)
    one_shot(32'h7F80_0000);   // infinity          (R7)
    one_shot(32'h7FC0_0001);   // NaN               (R7)
    one_shot(32'h7E80_0001);   // E=253 nonzero -> below range (R8)
    one_shot(32'h7F00_0000);   // E=254 zero fraction -> below range (R8)
    one_shot(32'h7E80_0000);   // E=253 zero fraction -> exponent 1 (R5)
    one_shot(32'h7E00_0001);   // E=252 nonzero -> exponent 1 (R4)
  endtask

  // R2: back-to-back stream, results in order
  task automatic t_stream();
    logic [31:0] ops [40];
    int          got;
    logic [31:0] r;
    for (int i = 0; i < 40; i++) begin
      r      = next_rand();
      ops[i] = {r[31], 8'(1 + (next_rand() % 252)), r[22:15], 1'b0, r[13:0]};
    end
    got = 0;
    for (int k = 0; k < 46; k++) begin
      @(negedge clk);
      if (out_valid) begin
        if (got < 40) check_result(ops[got], out_valid, out_invalid, out_data);
        got++;
      end
      if (k < 40) begin in_valid = 1'b1; in_data = ops[k]; end
      else        begin in_valid = 1'b0; in_data = '0; end
    end
    chk(got == 40, "R2", "stream result count", longint'(got), 40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_unity();
    t_directed();
    t_exceptions();
    t_stream();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule